// File: doc/BRIEF.md
# ARINC 429 Receive Channel

This block is one receive channel of a 429-style serial bus interface. The line receiver in front of it has already turned the bipolar return-to-zero signal into two logic levels: one pin for the positive half and one for the negative half. Both pins low means null. The block samples those pins on a sample-clock enable. That enable runs at 10 times the nominal bit rate in high-speed mode and 80 times in low-speed mode, as set by a speed input. The block qualifies each HI or LO pulse as a bit, shifts the bits into a 32-bit word and ends the word on a long null gap. It then offers the word on a valid/ready output together with an odd-parity error flag and its channel number.

The speed input and the sample-clock enable are shared by a receiver pair. Channels 0 and 1 use one setting and channels 2 and 3 use the other; the pairing is wired outside this block. For self-test, a wraparound input replaces the line with a transmitter's output pair. Channels 0 and 1 are connected to transmitter 0, and channels 2 and 3 to transmitter 1. Odd-numbered channels swap the HI and LO halves, so every looped-back bit arrives inverted.

On the output, `out_valid` stays high, with data and flags held still, until `out_ready` is seen high at a clock edge. There is one holding slot. A word that completes while the slot still holds an unaccepted word is dropped and reported on `frame_err`. A malformed frame is also reported on `frame_err`.

Top module: `a429_rx_chan`

## Requirements
- R1: In reset and on the first clock after reset, `out_valid` and `frame_err` are 0.
- R2: In high-speed mode (`speed_lo`=0), a frame of 32 bits spaced 10 sample ticks apart is delivered as one word. The first bit received lands in `out_data[0]` and the last in `out_data[31]`. A HI pulse is a 1 and a LO pulse is a 0.
- R3: In low-speed mode (`speed_lo`=1), frames with 80 sample ticks per bit are decoded the same way.
- R4: Frames whose bit period is 5% shorter or 5% longer than nominal, in either mode, are decoded without error.
- R5: A bit is accepted once its level has been held for 3 consecutive sample ticks (high speed) or 20 (low speed). A shorter pulse is not a bit.
- R6: A word is offered only after the line has been idle for more than two bit times after its last bit. It is never offered while bits are still arriving 1 bit time apart.
- R7: A frame that ends its gap with fewer than 32 bits offers no word and gives one-cycle pulse on `frame_err`.
- R8: A frame with more than 32 bits before its gap offers no word and gives one `frame_err` pulse. The next good frame is decoded normally.
- R9: `out_par_err` is 1 exactly when the delivered 32-bit word has an even number of ones.
- R10: `out_chan` equals the channel number set by the parameter `CHAN_ID`.
- R11: With `wrap_en`=1, the line pins are ignored and the transmitter pins are decoded instead, inverted (HI and LO swapped) when `CHAN_ID` is odd. With `wrap_en`=0, the transmitter pins are ignored.
- R12: While `out_valid`=1 and `out_ready`=0, the output word and flags hold. A word completing then is dropped with one `frame_err` pulse, and the held word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| samp_en | input | 1 | Sample-clock enable, 10x or 80x the bit rate |
| speed_lo | input | 1 | 1 selects low-speed qualification and timeout |
| wrap_en | input | 1 | 1 decodes the transmitter pins instead of the line |
| line_hi | input | 1 | Line positive half, logic level |
| line_lo | input | 1 | Line negative half, logic level |
| tx_hi | input | 1 | Looped-back transmitter positive half |
| tx_lo | input | 1 | Looped-back transmitter negative half |
| out_ready | input | 1 | Consumer accepts the offered word |
| out_valid | output | 1 | A word is offered |
| out_data | output | 32 | Received word, first bit in bit 0 |
| out_par_err | output | 1 | Word fails the odd-parity check |
| out_chan | output | 2 | Channel number |
| frame_err | output | 1 | One-cycle pulse: bad frame or dropped word |

## Verification
If the run-length counter or the arming state of the bit qualifier goes wrong, bits are lost or doubled. The port then shows a word that never appears (one `frame_err` pulse instead) or a word shifted by one bit. That shows up at the end of the same frame, about three bit times after the last bit. A wrong frame-timeout limit shows up at the same point, as a word offered too early or not at all. A fault in the holding slot shows up on the first stalled cycle as data that changes under `out_valid`, or as a missing drop pulse.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int unsigned WORD_W = 32;

  // Line state as {hi, lo}
  typedef enum logic [1:0] {
    LV_NULL = 2'b00,
    LV_LO   = 2'b01,
    LV_HI   = 2'b10,
    LV_BAD  = 2'b11
  } a429_lvl_e;

  function automatic logic lvl_is_pulse(input a429_lvl_e l);
    return (l == LV_HI) || (l == LV_LO);
  endfunction
endpackage

// File: rtl/a429_rx_front.sv
// Source select (line or looped-back transmitter), optional swap, synchronizer.
module a429_rx_front
  import a429_rx_pkg::*;
#(
  parameter bit          INVERT      = 1'b0,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wrap_en,
  input  logic      line_hi,
  input  logic      line_lo,
  input  logic      tx_hi,
  input  logic      tx_lo,
  output a429_lvl_e lvl
);
  logic [1:0] tx_pair;
  logic [1:0] src_pair;
  logic [1:0] sync_q [SYNC_STAGES];

  generate
    if (INVERT) begin : g_swap
      assign tx_pair = {tx_lo, tx_hi};
    end else begin : g_pass
      assign tx_pair = {tx_hi, tx_lo};
    end
  endgenerate

  assign src_pair = wrap_en ? tx_pair : {line_hi, line_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= 2'b00;
    end else begin
      sync_q[0] <= src_pair;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign lvl = a429_lvl_e'(sync_q[SYNC_STAGES-1]);
endmodule

// File: rtl/a429_rx_bitdet.sv
// Qualifies HI/LO pulses held for a minimum run of sample ticks.
module a429_rx_bitdet
  import a429_rx_pkg::*;
#(
  parameter int unsigned HS_MIN = 3,
  parameter int unsigned LS_MIN = 20
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      samp_en,
  input  logic      speed_lo,
  input  a429_lvl_e lvl,
  output logic      bit_stb,
  output logic      bit_val
);
  localparam int unsigned RUN_MAX = (LS_MIN > HS_MIN) ? LS_MIN : HS_MIN;
  localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] min_sel;
  logic [RUN_W:0]   run_inc;
  a429_lvl_e        prev_q;
  logic             armed_q;
  logic             same_lvl;
  logic             fire;

  assign min_sel  = speed_lo ? RUN_W'(LS_MIN) : RUN_W'(HS_MIN);
  assign run_inc  = {1'b0, run_q} + 1'b1;
  assign same_lvl = lvl_is_pulse(lvl) && (lvl == prev_q);
  assign fire     = samp_en && armed_q && same_lvl && (run_inc >= {1'b0, min_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      prev_q  <= LV_NULL;
      armed_q <= 1'b1;
      bit_stb <= 1'b0;
      bit_val <= 1'b0;
    end else begin
      bit_stb <= 1'b0;
      if (samp_en) begin
        prev_q <= lvl;
        if (!lvl_is_pulse(lvl)) begin
          run_q   <= '0;
          armed_q <= 1'b1;
        end else if (!same_lvl) begin
          run_q   <= RUN_W'(1);
          armed_q <= 1'b1;
        end else if (run_q != RUN_W'(RUN_MAX)) begin
          run_q <= run_inc[RUN_W-1:0];
        end
        if (fire) begin
          bit_stb <= 1'b1;
          bit_val <= (lvl == LV_HI);
          armed_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/a429_rx_frame.sv
// Word assembly, gap timeout, frame checks and the single output slot.
module a429_rx_frame
  import a429_rx_pkg::*;
#(
  parameter int unsigned HS_RATIO = 10,
  parameter int unsigned LS_RATIO = 80,
  parameter int unsigned GAP_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              speed_lo,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_par_err,
  output logic              frame_err
);
  localparam int unsigned TMO_HS = GAP_BITS * HS_RATIO;
  localparam int unsigned TMO_LS = GAP_BITS * LS_RATIO;
  localparam int unsigned TMO_MX = (TMO_LS > TMO_HS) ? TMO_LS : TMO_HS;
  localparam int unsigned IDLE_W = $clog2(TMO_MX + 1);
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic [IDLE_W-1:0] idle_q;
  logic [IDLE_W-1:0] tmo_last;
  logic              over_q;
  logic              active;
  logic              timeout;
  logic              word_done;
  logic              slot_free;

  assign tmo_last  = speed_lo ? IDLE_W'(TMO_LS - 1) : IDLE_W'(TMO_HS - 1);
  assign active    = (bitcnt_q != '0) || over_q;
  assign timeout   = active && samp_en && !bit_stb && (idle_q == tmo_last);
  assign word_done = timeout && !over_q && (bitcnt_q == CNT_W'(WORD_W));
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      bitcnt_q    <= '0;
      idle_q      <= '0;
      over_q      <= 1'b0;
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_par_err <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      frame_err <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;

      if (bit_stb) begin
        idle_q <= '0;
        if (bitcnt_q == CNT_W'(WORD_W)) begin
          over_q <= 1'b1;
        end else begin
          shreg_q  <= {bit_val, shreg_q[WORD_W-1:1]};
          bitcnt_q <= bitcnt_q + 1'b1;
        end
      end else if (timeout) begin
        idle_q   <= '0;
        bitcnt_q <= '0;
        over_q   <= 1'b0;
        if (word_done && slot_free) begin
          out_valid   <= 1'b1;
          out_data    <= shreg_q;
          out_par_err <= ~(^shreg_q);
        end else begin
          frame_err <= 1'b1;
        end
      end else if (samp_en && active) begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/a429_rx_chan.sv
module a429_rx_chan
  import a429_rx_pkg::*;
#(
  parameter int unsigned CHAN_ID  = 0,
  parameter int unsigned CHAN_W   = 2,
  parameter int unsigned HS_RATIO = 10,
  parameter int unsigned LS_RATIO = 80,
  parameter int unsigned HS_MIN   = 3,
  parameter int unsigned LS_MIN   = 20,
  parameter int unsigned GAP_BITS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              samp_en,
  input  logic              speed_lo,
  input  logic              wrap_en,
  input  logic              line_hi,
  input  logic              line_lo,
  input  logic              tx_hi,
  input  logic              tx_lo,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_par_err,
  output logic [CHAN_W-1:0] out_chan,
  output logic              frame_err
);
  localparam bit INVERT = (CHAN_ID % 2) == 1;

  a429_lvl_e lvl;
  logic      bit_stb;
  logic      bit_val;

  a429_rx_front #(.INVERT(INVERT), .SYNC_STAGES(2)) front_i (
    .clk(clk), .rst_n(rst_n), .wrap_en(wrap_en),
    .line_hi(line_hi), .line_lo(line_lo), .tx_hi(tx_hi), .tx_lo(tx_lo),
    .lvl(lvl)
  );

  a429_rx_bitdet #(.HS_MIN(HS_MIN), .LS_MIN(LS_MIN)) bitdet_i (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .speed_lo(speed_lo),
    .lvl(lvl), .bit_stb(bit_stb), .bit_val(bit_val)
  );

  a429_rx_frame #(.HS_RATIO(HS_RATIO), .LS_RATIO(LS_RATIO), .GAP_BITS(GAP_BITS)) frame_i (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .speed_lo(speed_lo),
    .bit_stb(bit_stb), .bit_val(bit_val), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_par_err(out_par_err),
    .frame_err(frame_err)
  );

  assign out_chan = CHAN_W'(CHAN_ID);
endmodule

// File: rtl/a429_rx_chan_chk.sv
module a429_rx_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_par_err,
  input logic        frame_err,
  input logic        bit_stb
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !frame_err));

  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_par_err)));

  a_r5_bit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);

  a_r6_no_word_after_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !$past(bit_stb));

  a_r7_err_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);

  a_r9_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_par_err == ~(^out_data)));
endmodule

bind a429_rx_chan a429_rx_chan_chk chk_i (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_par_err(out_par_err), .frame_err(frame_err),
  .bit_stb(bit_stb)
);

// File: tb/a429_rx_chan_tb_top.sv
module a429_rx_chan_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic samp_en = 1'b1;
  logic speed_lo = 1'b0;
  logic wrap_en = 1'b0;
  logic line_hi = 1'b0, line_lo = 1'b0;
  logic tx_hi = 1'b0, tx_lo = 1'b0;
  logic out_ready = 1'b0;
  logic        out_valid, out_par_err, frame_err;
  logic [31:0] out_data;
  logic [1:0]  out_chan;
  logic        o_valid, o_par, o_err;
  logic [31:0] o_data;
  logic [1:0]  o_chan;

  int chk_cnt = 0;
  int fail_cnt = 0;
  int err_cnt = 0;
  int odd_seen = 0;
  logic [31:0] odd_last = '0;
  int samp_div = 1;
  int div_cnt = 0;
  bit use_tx = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  a429_rx_chan #(.CHAN_ID(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .speed_lo(speed_lo),
    .wrap_en(wrap_en), .line_hi(line_hi), .line_lo(line_lo),
    .tx_hi(tx_hi), .tx_lo(tx_lo), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_par_err(out_par_err),
    .out_chan(out_chan), .frame_err(frame_err)
  );

  a429_rx_chan #(.CHAN_ID(3)) dut_odd_i (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .speed_lo(speed_lo),
    .wrap_en(wrap_en), .line_hi(line_hi), .line_lo(line_lo),
    .tx_hi(tx_hi), .tx_lo(tx_lo), .out_ready(1'b1),
    .out_valid(o_valid), .out_data(o_data), .out_par_err(o_par),
    .out_chan(o_chan), .frame_err(o_err)
  );

  always @(negedge clk) begin
    if (div_cnt + 1 >= samp_div) begin
      div_cnt <= 0;
      samp_en <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 1;
      samp_en <= 1'b0;
    end
    if (rst_n && frame_err) err_cnt <= err_cnt + 1;
    if (rst_n && o_valid) begin
      odd_seen <= odd_seen + 1;
      odd_last <= o_data;
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic h, input logic l, input int clks);
    if (use_tx) begin
      tx_hi = h; tx_lo = l;
    end else begin
      line_hi = h; line_lo = l;
    end
    repeat (clks) @(negedge clk);
  endtask

  // n bits from bits[0] upward; bit index gi uses pulse length gh instead of hi_c
  task automatic send_bits(input logic [63:0] bits, input int n, input int hi_c,
                           input int per_c, input int gi, input int gh);
    for (int i = 0; i < n; i++) begin
      int h;
      h = (i == gi) ? gh : hi_c;
      drive(bits[i], ~bits[i], h);
      drive(1'b0, 1'b0, per_c - h);
    end
  endtask

  task automatic accept();
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  // Send one good word and check the delivery on dut_i
  task automatic rx_word(input logic [31:0] w, input int hi_c, input int per_c, input string req);
    int e0;
    e0 = err_cnt;
    send_bits({32'h0, w}, 32, hi_c, per_c, -1, 0);
    repeat (per_c) @(negedge clk);
    check(!out_valid, "R6 early", {63'h0, out_valid}, 64'h0);
    repeat (5 * per_c) @(negedge clk);
    check(out_valid && out_data == w, req, {31'h0, out_valid, out_data}, {32'h1, w});
    check(out_par_err == ~(^w), "R9", {63'h0, out_par_err}, {63'h0, ~(^w)});
    check(err_cnt == e0, {req, " no err"}, err_cnt, e0);
    accept();
    check(!out_valid, {req, " accepted"}, {63'h0, out_valid}, 64'h0);
  endtask

  // Bad frame: no word, one error pulse
  task automatic bad_frame(input logic [63:0] bits, input int n, input int gi, input int gh, input string req);
    int e0;
    e0 = err_cnt;
    send_bits(bits, n, 5, 10, gi, gh);
    repeat (60) @(negedge clk);
    check(!out_valid, {req, " no word"}, {63'h0, out_valid}, 64'h0);
    check(err_cnt == e0 + 1, {req, " err pulse"}, err_cnt, e0 + 1);
  endtask

  initial begin : main
    logic [31:0] pats [8];
    int e0, s0;
    pats = '{32'h0000_0000, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_5678,
             32'h8000_0001, 32'h7FFF_FFFE, 32'hDEAD_BEEF, 32'h0F0F_00F1};
    repeat (3) @(negedge clk);
    check(!out_valid && !frame_err, "R1 in reset", {62'h0, out_valid, frame_err}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !frame_err, "R1 after reset", {62'h0, out_valid, frame_err}, 64'h0);
    check(out_chan == 2'd0 && o_chan == 2'd3, "R10", {60'h0, out_chan, o_chan}, 64'h3);
    repeat (5) @(negedge clk);

    // R2: high-speed walking ones and zeros, plus patterns
    for (int b = 0; b < 32; b++) rx_word(32'h1 << b, 5, 10, "R2 walk1");
    for (int b = 0; b < 32; b += 3) rx_word(~(32'h1 << b), 5, 10, "R2 walk0");
    foreach (pats[k]) rx_word(pats[k], 5, 10, "R2 pattern");

    // R3: low-speed
    speed_lo = 1'b1;
    for (int k = 0; k < 4; k++) rx_word(pats[k + 2], 40, 80, "R3 low speed");

    // R4: +-5% rate in low speed (76/84 ticks per bit)
    rx_word(32'hC3C3_3C3C, 38, 76, "R4 ls fast");
    rx_word(32'h6996_9669, 42, 84, "R4 ls slow");
    speed_lo = 1'b0;

    // R4: +-5% in high speed, 2 clocks per tick (19/21 clocks per bit)
    samp_div = 2;
    repeat (4) @(negedge clk);
    rx_word(32'h5555_AAAA, 9, 19, "R4 hs fast");
    rx_word(32'h0123_4567, 11, 21, "R4 hs slow");
    samp_div = 1;
    repeat (4) @(negedge clk);

    // R5: a 3-tick pulse is a bit; a 2-tick pulse is not
    rx_word(32'hBEEF_0102, 3, 10, "R5 min pulse");
    bad_frame({32'h0, 32'h0000_FFFF}, 32, 7, 2, "R5 short pulse");

    // R7: short frame, then R8: 33 bits
    bad_frame({48'h0, 16'hABCD}, 16, -1, 0, "R7");
    bad_frame({31'h0, 1'b1, 32'h1357_9BDF}, 33, -1, 0, "R8");
    rx_word(32'h2468_ACE0, 5, 10, "R8 recovery");

    // R11: wraparound; line held HI and must be ignored
    wrap_en = 1'b1;
    line_hi = 1'b1; line_lo = 1'b0;
    use_tx = 1'b1;
    repeat (20) @(negedge clk);
    s0 = odd_seen;
    rx_word(32'h9ABC_DEF1, 5, 10, "R11 wrap ch0");
    check(odd_seen == s0 + 1 && odd_last == 32'h6543_210E, "R11 wrap ch3 inverted",
          {32'h0, odd_last}, {32'h0, 32'h6543_210E});
    // wrap off: transmitter pins ignored
    wrap_en = 1'b0;
    line_hi = 1'b0;
    repeat (20) @(negedge clk);
    e0 = err_cnt;
    s0 = odd_seen;
    send_bits({32'h0, 32'h1111_2222}, 32, 5, 10, -1, 0);
    repeat (60) @(negedge clk);
    check(!out_valid && err_cnt == e0 && odd_seen == s0, "R11 tx ignored",
          {31'h0, out_valid, err_cnt[31:0]}, {32'h0, e0[31:0]});
    use_tx = 1'b0;

    // R12: stalled slot keeps word A, word B dropped with error
    e0 = err_cnt;
    send_bits({32'h0, 32'hAAAA_0001}, 32, 5, 10, -1, 0);
    repeat (60) @(negedge clk);
    check(out_valid && out_data == 32'hAAAA_0001, "R12 held", {32'h0, out_data}, {32'h0, 32'hAAAA_0001});
    send_bits({32'h0, 32'hBBBB_0002}, 32, 5, 10, -1, 0);
    repeat (60) @(negedge clk);
    check(out_valid && out_data == 32'hAAAA_0001, "R12 kept", {32'h0, out_data}, {32'h0, 32'hAAAA_0001});
    check(err_cnt == e0 + 1, "R12 drop pulse", err_cnt, e0 + 1);
    accept();
    check(!out_valid, "R12 released", {63'h0, out_valid}, 64'h0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk_cnt++;
      fail_cnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", chk_cnt, fail_cnt);
      $finish;
    end
  end
endmodule